// File: doc/BRIEF.md
# Serial Frame Receiver with Error Interrupt Routing

This block takes an asynchronous serial line and turns each frame on it into a byte in a receive buffer. The frame has a low start bit, eight data bits least significant first, an optional parity bit and one stop bit. The line is sampled at sixteen baud ticks per bit. The baud tick is an enable input that comes from a rate generator outside the block. A two-flop synchronizer sits in front of the edge detector. A start is accepted only if the line is still low half a bit after the falling edge.

At the end of a frame the byte is always written to the buffer, even when the frame has errors. Three sticky flags record parity errors, framing errors and overruns. A buffer-read strobe clears these flags and the buffer-full state. An error interrupt pulse is raised for any error. A routing input decides whether an errored frame also raises the normal completion pulse. If the enable input is dropped during a frame, the frame is abandoned: the buffer, the flags and both interrupts are left untouched.

The controller has five states. IDLE waits for a falling edge. START_CHK counts eight ticks and then confirms the start or returns to IDLE. DATA takes one bit every sixteen ticks until eight bits are in. PARITY takes the parity bit and is visited only when parity is enabled. STOP samples the stop bit, completes the frame and goes back to IDLE. The transitions are:
- IDLE to START_CHK on a falling edge.
- START_CHK to DATA on a low sample, or to IDLE on a high sample.
- DATA to PARITY or STOP after the last bit.
- PARITY to STOP.
- STOP to IDLE.
- Any state to IDLE when the enable input is low.

Top module: `srx_receiver`

## Requirements
- R1: While rx_en is 0, changes on ser_in have no effect. No interrupt fires, and rx_data, the flags and buf_full keep their values.
- R2: A falling edge on the synchronized line starts a check. If the line is sampled high 8 ticks later, the receiver returns to IDLE with no output change. A low pulse shorter than half a bit is therefore ignored.
- R3: Sampling advances only on cycles with baud_tick = 1, at 16 ticks per bit. Data bits are taken at 16-tick spacing, and the first data bit received becomes rx_data[0].
- R4: When the stop bit is sampled, the received byte is written to rx_data and buf_full is set. This happens whether or not the frame has errors.
- R5: When par_en = 1, one parity bit follows the eighth data bit. With par_odd = 0 the data bits and the parity bit together must hold an even number of ones; with par_odd = 1, an odd number. A mismatch sets perr. When par_en = 0, no parity bit is expected.
- R6: A stop bit sampled as 0 sets ferr.
- R7: A frame that completes while buf_full = 1, with no buf_rd in the same cycle, sets oerr. perr, ferr and oerr stay set across later frames until a read.
- R8: buf_rd clears buf_full, perr, ferr and oerr on the next clock edge.
- R9: At frame completion, err_irq pulses for one cycle if the frame has a parity, framing or overrun error. done_irq pulses for one cycle unless the frame has an error and err_route = 1.
- R10: Dropping rx_en during a frame returns the receiver to IDLE at the next edge. The buffer and the flags are not changed, and no interrupt fires for that frame.
- R11: After reset, rx_data is 0, all flags and buf_full are 0, no interrupt is active, and the line is taken as idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| baud_tick | input | 1 | Sample enable, 16 per bit |
| ser_in | input | 1 | Asynchronous serial line |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| err_route | input | 1 | 1 = errored frame raises only err_irq |
| buf_rd | input | 1 | Buffer read strobe |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread byte |
| perr | output | 1 | Sticky parity error |
| ferr | output | 1 | Sticky framing error |
| oerr | output | 1 | Sticky overrun error |
| done_irq | output | 1 | Frame completion pulse |
| err_irq | output | 1 | Frame error pulse |

## Verification
Each kind of internal fault shows up at the ports in its own way:
- A tick counter off by one, or a wrong mid-bit phase, shifts every sample point. The byte then appears rotated or corrupted in rx_data at the end of the very next frame.
- A wrong bit index turns up as a missing or extra bit, and the parity and stop checks then land on the wrong bit.
- A controller that does not return to IDLE on an abort or a false start shows a spurious pulse on done_irq or err_irq. It can also leave the next clean frame wrongly decoded. Both are visible within one frame time.

Faults in the error flags show up differently. Sticky flags that clear too early, or never clear, are seen only at the following frame or read. For that reason the bench runs frames back to back without reads.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_CHK,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } srx_state_t;
endpackage

// File: rtl/srx_sync.sv
// Two-flop synchronizer for the serial line, plus falling-edge detection.
// Everything resets to the idle-high level.
module srx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic line,
    output logic line_fall
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign line      = sync_q;
    assign line_fall = prev_q & ~sync_q;
endmodule

// File: rtl/srx_tick_cnt.sv
// Sample counter that moves on baud ticks. It reports the half-bit and
// full-bit points as single-cycle strobes.
module srx_tick_cnt #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic half_hit,
    output logic full_hit
);
    localparam int CNT_W = $clog2(OVERSAMPLE) + 1;
    localparam int HALF  = OVERSAMPLE / 2;

    logic [CNT_W-1:0] cnt_q;

    assign half_hit = tick && (cnt_q == CNT_W'(HALF - 1));
    assign full_hit = tick && (cnt_q == CNT_W'(OVERSAMPLE - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= full_hit ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/srx_shift.sv
// Right-shifting register: the first bit in ends up in bit 0.
module srx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clr) begin
            data <= '0;
        end else if (shift_en) begin
            data <= {bit_in, data[DATA_W-1:1]};
        end
    end
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver #(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              baud_tick,
    input  logic              ser_in,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              err_route,
    input  logic              buf_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              buf_full,
    output logic              perr,
    output logic              ferr,
    output logic              oerr,
    output logic              done_irq,
    output logic              err_irq
);
    import srx_pkg::*;

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    srx_state_t        state;
    srx_state_t        nxt;
    logic              line;
    logic              line_fall;
    logic              half_hit;
    logic              full_hit;
    logic              cnt_clr;
    logic              shift_en;
    logic              par_cap;
    logic              frame_end;
    logic              start_ok;
    logic [IDX_W-1:0]  bit_idx;
    logic              par_bit;
    logic [DATA_W-1:0] shift_q;
    logic              new_perr;
    logic              new_ferr;
    logic              new_oerr;
    logic              any_err;

    srx_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .d_async   (ser_in),
        .line      (line),
        .line_fall (line_fall)
    );

    srx_tick_cnt #(.OVERSAMPLE(OVERSAMPLE)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .tick     (baud_tick),
        .half_hit (half_hit),
        .full_hit (full_hit)
    );

    srx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_ok),
        .shift_en (shift_en),
        .bit_in   (line),
        .data     (shift_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and per-cycle strobes
    always_comb begin
        nxt       = state;
        cnt_clr   = 1'b0;
        shift_en  = 1'b0;
        par_cap   = 1'b0;
        frame_end = 1'b0;
        start_ok  = 1'b0;
        if (!rx_en) begin
            nxt     = ST_IDLE;
            cnt_clr = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt_clr = 1'b1;
                    if (line_fall) begin
                        nxt = ST_START_CHK;
                    end
                end
                ST_START_CHK: begin
                    if (half_hit) begin
                        cnt_clr = 1'b1;
                        if (line) begin
                            nxt = ST_IDLE;
                        end else begin
                            start_ok = 1'b1;
                            nxt      = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (full_hit) begin
                        shift_en = 1'b1;
                        if (bit_idx == IDX_W'(DATA_W - 1)) begin
                            nxt = par_en ? ST_PARITY : ST_STOP;
                        end
                    end
                end
                ST_PARITY: begin
                    if (full_hit) begin
                        par_cap = 1'b1;
                        nxt     = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (full_hit) begin
                        frame_end = 1'b1;
                        nxt       = ST_IDLE;
                    end
                end
                default: begin
                    nxt = ST_IDLE;
                end
            endcase
        end
    end

    // Bit index and captured parity bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            par_bit <= 1'b0;
        end else begin
            if (start_ok) begin
                bit_idx <= '0;
            end else if (shift_en) begin
                bit_idx <= bit_idx + 1'b1;
            end
            if (par_cap) begin
                par_bit <= line;
            end
        end
    end

    // Errors of the frame that completes in this cycle
    assign new_perr = par_en && (par_bit != ((^shift_q) ^ par_odd));
    assign new_ferr = ~line;
    assign new_oerr = buf_full && !buf_rd;
    assign any_err  = new_perr || new_ferr || new_oerr;

    // Buffer, sticky status and interrupt pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            buf_full <= 1'b0;
            perr     <= 1'b0;
            ferr     <= 1'b0;
            oerr     <= 1'b0;
            done_irq <= 1'b0;
            err_irq  <= 1'b0;
        end else begin
            done_irq <= 1'b0;
            err_irq  <= 1'b0;
            if (buf_rd) begin
                buf_full <= 1'b0;
                perr     <= 1'b0;
                ferr     <= 1'b0;
                oerr     <= 1'b0;
            end
            if (frame_end) begin
                rx_data  <= shift_q;
                buf_full <= 1'b1;
                perr     <= (perr && !buf_rd) || new_perr;
                ferr     <= (ferr && !buf_rd) || new_ferr;
                oerr     <= (oerr && !buf_rd) || new_oerr;
                err_irq  <= any_err;
                done_irq <= !any_err || !err_route;
            end
        end
    end
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              buf_rd,
    input logic              err_route,
    input logic [DATA_W-1:0] rx_data,
    input logic              buf_full,
    input logic              perr,
    input logic              ferr,
    input logic              oerr,
    input logic              done_irq,
    input logic              err_irq,
    input srx_pkg::srx_state_t state
);
    import srx_pkg::*;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);

    // R9
    err_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && $past(err_route)) |-> !done_irq);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (perr || ferr || oerr));

    // R4
    load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq || err_irq) |-> buf_full);

    // R10
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> ($stable(rx_data) && !done_irq && !err_irq));

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == ST_IDLE));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |=> !oerr);
endmodule

bind srx_receiver srx_checker #(.DATA_W(DATA_W)) u_srx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .buf_rd    (buf_rd),
    .err_route (err_route),
    .rx_data   (rx_data),
    .buf_full  (buf_full),
    .perr      (perr),
    .ferr      (ferr),
    .oerr      (oerr),
    .done_irq  (done_irq),
    .err_irq   (err_irq),
    .state     (state)
);

// File: tb/test_srx_receiver.sv
`timescale 1ns/1ps
module test_srx_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       ser_in = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       err_route = 1'b0;
    logic       buf_rd = 1'b0;
    logic [7:0] rx_data;
    logic       buf_full, perr, ferr, oerr, done_irq, err_irq;

    int compared = 0;
    int mismatched = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int tick_div = 1;
    int tick_ph = 0;
    bit finished = 0;

    // Model of the buffer and sticky flags
    bit m_full = 0, m_perr = 0, m_ferr = 0, m_oerr = 0;

    always #2.5 clk = ~clk;

    srx_receiver i_srx_receiver (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_tick(baud_tick),
        .ser_in(ser_in), .par_en(par_en), .par_odd(par_odd),
        .err_route(err_route), .buf_rd(buf_rd), .rx_data(rx_data),
        .buf_full(buf_full), .perr(perr), .ferr(ferr), .oerr(oerr),
        .done_irq(done_irq), .err_irq(err_irq)
    );

    // Baud tick generator: one tick every tick_div cycles
    always @(negedge clk) begin
        if (tick_ph >= tick_div - 1) begin
            tick_ph   <= 0;
            baud_tick <= 1'b1;
        end else begin
            tick_ph   <= tick_ph + 1;
            baud_tick <= 1'b0;
        end
    end

    // Interrupt pulse counters, sampled away from the active edge
    always @(negedge clk) begin
        if (done_irq) done_cnt <= done_cnt + 1;
        if (err_irq)  err_cnt  <= err_cnt + 1;
    end

    // Fields: [13:6] data, [5] parity on, [4] odd, [3] corrupt parity,
    // [2] stop level, [1] err_route, [0] read buffer before the frame
    localparam logic [13:0] VEC [8] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'h3C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {8'h81, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h5A, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'h96, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_buf();
        @(negedge clk) buf_rd = 1'b1;
        @(negedge clk) buf_rd = 1'b0;
        m_full = 0; m_perr = 0; m_ferr = 0; m_oerr = 0;
    endtask

    // Sends start, 8 data bits LSB first, optional parity, stop.
    // abort_bit >= 0 drops rx_en at the start of that bit slot.
    task automatic send_frame(input logic [7:0] d, input bit pe, input bit pb,
                              input bit stopv, input int abort_bit);
        int nbits;
        logic [10:0] bits;
        nbits = pe ? 11 : 10;
        bits  = '1;
        bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) bits[i+1] = d[i];
        if (pe) begin
            bits[9]  = pb;
            bits[10] = stopv;
        end else begin
            bits[9]  = stopv;
        end
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            if (b == abort_bit) rx_en = 1'b0;
            ser_in = bits[b];
            repeat (16 * tick_div - 1) @(negedge clk);
        end
        @(negedge clk) ser_in = 1'b1;
        repeat (20 * tick_div) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int d0, e0;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 rx_data", rx_data, 0);
        chk("R11 flags", {buf_full, perr, ferr, oerr, done_irq, err_irq}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 after release", {buf_full, perr, ferr, oerr, done_irq, err_irq}, 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // Table walk: R4 R5 R6 R7 R9
        for (int v = 0; v < 8; v++) begin
            logic [7:0] d;
            bit pe, po, bad, stp, rt, rd, pb, np, nf, no, ae;
            {d, pe, po, bad, stp, rt, rd} = VEC[v];
            if (rd) read_buf();
            par_en = pe; par_odd = po; err_route = rt;
            pb = (^d) ^ po ^ bad;
            np = pe && bad;
            nf = !stp;
            no = m_full;
            ae = np || nf || no;
            m_perr |= np; m_ferr |= nf; m_oerr |= no; m_full = 1;
            d0 = done_cnt; e0 = err_cnt;
            send_frame(d, pe, pb, stp, -1);
            chk("R4 data", rx_data, d);
            chk("R4 buf_full", buf_full, 1);
            chk("R5 perr", perr, m_perr);
            chk("R6 ferr", ferr, m_ferr);
            chk("R7 oerr", oerr, m_oerr);
            chk("R9 done pulses", done_cnt - d0, (!ae || !rt) ? 1 : 0);
            chk("R9 err pulses", err_cnt - e0, ae ? 1 : 0);
        end

        // R8: read clears the flags and buf_full
        read_buf();
        @(negedge clk);
        chk("R8 cleared", {buf_full, perr, ferr, oerr}, 0);
        chk("R8 data kept", rx_data, 8'h96);

        // R10: abort in the middle of the data bits
        par_en = 1'b0; err_route = 1'b0;
        d0 = done_cnt; e0 = err_cnt;
        send_frame(8'h4E, 0, 0, 1, 5);
        chk("R10 abort data", rx_data, 8'h96);
        chk("R10 abort flags", {buf_full, perr, ferr, oerr}, 0);
        chk("R10 abort irqs", (done_cnt - d0) + (err_cnt - e0), 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);
        d0 = done_cnt;
        send_frame(8'h4E, 0, 0, 1, -1);
        chk("R10 recovery data", rx_data, 8'h4E);
        chk("R10 recovery done", done_cnt - d0, 1);
        read_buf();

        // R1: whole frame while disabled
        rx_en = 1'b0;
        d0 = done_cnt; e0 = err_cnt;
        send_frame(8'h11, 0, 0, 0, -1);
        chk("R1 data", rx_data, 8'h4E);
        chk("R1 flags", {buf_full, perr, ferr, oerr}, 0);
        chk("R1 irqs", (done_cnt - d0) + (err_cnt - e0), 0);
        rx_en = 1'b1;
        repeat (4) @(negedge clk);

        // R2: short low glitch is rejected, then a real frame decodes
        d0 = done_cnt; e0 = err_cnt;
        @(negedge clk) ser_in = 1'b0;
        repeat (3) @(negedge clk);
        ser_in = 1'b1;
        repeat (40) @(negedge clk);
        chk("R2 glitch irqs", (done_cnt - d0) + (err_cnt - e0), 0);
        chk("R2 glitch data", rx_data, 8'h4E);
        send_frame(8'hB7, 0, 0, 1, -1);
        chk("R2 after glitch data", rx_data, 8'hB7);
        chk("R2 after glitch done", done_cnt - d0, 1);
        read_buf();

        // R3: slow tick rate, one tick every 3 cycles
        tick_div = 3;
        repeat (6) @(negedge clk);
        d0 = done_cnt; e0 = err_cnt;
        par_en = 1'b1; par_odd = 1'b1;
        send_frame(8'hC3, 1, (^8'hC3) ^ 1'b1, 1, -1);
        chk("R3 slow data", rx_data, 8'hC3);
        chk("R3 slow done", done_cnt - d0, 1);
        chk("R3 slow no error", {err_cnt - e0, perr, ferr, oerr}, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule